// File: doc/BRIEF.md
# Warp Load Request Coalescer

This block accepts one load request covering a whole 32-lane warp. Every lane has an enable bit and the byte address of the 4-byte word it wants. The block reduces the enabled addresses to the smallest set of aligned memory blocks that holds all of them. A mode input selects the block size: 128-byte lines when caching, 32-byte segments when not caching. One transaction per block leaves on a valid/ready port, each carrying the aligned base address of its block.

Transactions leave in strictly rising address order, one per accepted handshake. While a request is being worked off, the block stays not-ready on its input. After the final transaction is taken, a one-cycle completion pulse carries two values: the number of transactions and the bytes moved. The bytes moved are that number times the block size. Comparing the bytes moved with the bytes the enabled lanes need shows how well the bus is used. A request with no enabled lanes issues nothing and completes at once. The block may accept a new request in the same cycle as it reports completion of the previous one.

Top module: `warp_coalescer`

## Requirements
- R1: With `req_mode` = 1 (caching), each transaction is one 128-byte line: `txn_addr` has bits [6:0] zero, and each line touched by an enabled lane is issued exactly once.
- R2: With `req_mode` = 0 (non-caching), each transaction is one 32-byte segment: `txn_addr` has bits [4:0] zero, and each segment touched by an enabled lane is issued exactly once.
- R3: 32 consecutive words starting on a 128-byte boundary, mapped to lanes in any order, give exactly 1 transaction in caching mode and 4 in non-caching mode.
- R4: 32 consecutive words not starting on a 128-byte boundary give 2 lines in caching mode. In non-caching mode they give 5 segments when the start is not 32-byte aligned, and 4 when it is.
- R5: When every enabled lane names the same word, one transaction is issued, and the bytes moved are 128 (caching) or 32 (non-caching).
- R6: Addresses spread over N distinct blocks give N transactions, and `done_bytes` = N × block size.
- R7: Lanes with their `req_active` bit clear add no transactions, whatever their address.
- R8: A request with `req_active` all zero issues no transaction. Its `done_valid` pulse comes in the cycle after acceptance, with count 0 and bytes 0.
- R9: Transactions leave in strictly ascending `txn_addr` order.
- R10: `req_ready` is low from the cycle after acceptance until the last transaction has been taken. While `txn_ready` is low, `txn_valid` stays high and `txn_addr` stays unchanged.
- R11: `done_valid` pulses in the cycle after the last transaction handshake. `done_count` equals the number of handshakes, and `done_bytes` equals the count times the block size.
- R12: After reset, `req_ready` = 1, `txn_valid` = 0 and `done_valid` = 0, including when reset falls during an unfinished request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_mode | input | 1 | 1 = 128-byte lines, 0 = 32-byte segments |
| req_active | input | 32 | Per-lane enable, bit i for lane i |
| req_addr | input | 1024 | Lane i byte address in bits [32i+31:32i] |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Transaction taken |
| txn_addr | output | 32 | Aligned base address of the block |
| done_valid | output | 1 | One-cycle completion pulse |
| done_count | output | 6 | Transactions issued for the request |
| done_bytes | output | 13 | Bytes moved for the request |

## Verification
Two things can happen in the same cycle: the completion pulse of one request and the acceptance of the next. The bench provokes this on every request. It drives each new request in the very cycle where it observes `done_valid` for the previous one. It then checks that `req_ready` is high in that cycle, that the finished request's count and bytes are correct, and that the new request's transactions, order and totals come out as if it had started from idle. Empty requests issued back to back make the overlap tighter still, because each one completes one cycle after acceptance.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } coal_state_e;

    typedef enum logic {
        GRAN_SEGMENT = 1'b0,
        GRAN_LINE    = 1'b1
    } coal_gran_e;

endpackage

// File: rtl/coal_lane_index.sv
module coal_lane_index #(
    parameter int LANES       = 32,
    parameter int ADDR_W      = 32,
    parameter int SEG_SHIFT   = 5,
    parameter int LINE_SHIFT  = 7,
    localparam int BLK_W      = ADDR_W - SEG_SHIFT
) (
    input  logic                      gran_line,
    input  logic [LANES*ADDR_W-1:0]   lane_addr,
    output logic [LANES*BLK_W-1:0]    lane_blk
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ADDR_W-1:0] a;
        logic [ADDR_W-1:0] shifted;
        assign a       = lane_addr[g*ADDR_W +: ADDR_W];
        assign shifted = gran_line ? (a >> LINE_SHIFT) : (a >> SEG_SHIFT);
        assign lane_blk[g*BLK_W +: BLK_W] = shifted[BLK_W-1:0];
    end

endmodule

// File: rtl/coal_min_pick.sv
module coal_min_pick #(
    parameter int LANES = 32,
    parameter int BLK_W = 27
) (
    input  logic [LANES-1:0]        pend,
    input  logic [LANES*BLK_W-1:0]  lane_blk,
    output logic                    any,
    output logic [BLK_W-1:0]        min_blk
);

    always_comb begin
        logic [BLK_W-1:0] best;
        logic             found;
        best  = '1;
        found = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (pend[i] && (!found || lane_blk[i*BLK_W +: BLK_W] < best)) begin
                best  = lane_blk[i*BLK_W +: BLK_W];
                found = 1'b1;
            end
        end
        any     = found;
        min_blk = best;
    end

endmodule

// File: rtl/coal_match_clear.sv
module coal_match_clear #(
    parameter int LANES = 32,
    parameter int BLK_W = 27
) (
    input  logic [LANES-1:0]        pend,
    input  logic [LANES*BLK_W-1:0]  lane_blk,
    input  logic [BLK_W-1:0]        sel_blk,
    output logic [LANES-1:0]        pend_left
);

    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign pend_left[g] = pend[g] && (lane_blk[g*BLK_W +: BLK_W] != sel_blk);
    end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int SEG_BYTES  = 32,
    parameter int LINE_BYTES = 128,
    localparam int SEG_SHIFT  = $clog2(SEG_BYTES),
    localparam int LINE_SHIFT = $clog2(LINE_BYTES),
    localparam int BLK_W      = ADDR_W - SEG_SHIFT,
    localparam int CNT_W      = $clog2(LANES + 1),
    localparam int BYTES_W    = $clog2(LANES * LINE_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_mode,
    input  logic [LANES-1:0]        req_active,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_addr,
    output logic                    done_valid,
    output logic [CNT_W-1:0]        done_count,
    output logic [BYTES_W-1:0]      done_bytes
);
    import coal_pkg::*;

    typedef struct packed {
        coal_state_e               state;
        coal_gran_e                gran;
        logic [LANES-1:0]          pend;
        logic [LANES*BLK_W-1:0]    blk;
        logic [CNT_W-1:0]          count;
        logic                      done;
        logic [CNT_W-1:0]          done_count;
        logic [BYTES_W-1:0]        done_bytes;
    } coal_regs_t;

    coal_regs_t r_q, r_d;

    logic [LANES*BLK_W-1:0] in_blk_w;
    logic                   any_w;
    logic [BLK_W-1:0]       min_blk_w;
    logic [LANES-1:0]       pend_left_w;
    logic [ADDR_W-1:0]      seg_base_w;

    coal_lane_index #(
        .LANES(LANES), .ADDR_W(ADDR_W),
        .SEG_SHIFT(SEG_SHIFT), .LINE_SHIFT(LINE_SHIFT)
    ) u_index (
        .gran_line (req_mode),
        .lane_addr (req_addr),
        .lane_blk  (in_blk_w)
    );

    coal_min_pick #(.LANES(LANES), .BLK_W(BLK_W)) u_pick (
        .pend     (r_q.pend),
        .lane_blk (r_q.blk),
        .any      (any_w),
        .min_blk  (min_blk_w)
    );

    coal_match_clear #(.LANES(LANES), .BLK_W(BLK_W)) u_clear (
        .pend      (r_q.pend),
        .lane_blk  (r_q.blk),
        .sel_blk   (min_blk_w),
        .pend_left (pend_left_w)
    );

    function automatic logic [BYTES_W-1:0] bytes_of(input logic [CNT_W-1:0] n,
                                                     input coal_gran_e g);
        logic [BYTES_W-1:0] wide;
        wide = BYTES_W'(n);
        return (g == GRAN_LINE) ? (wide << LINE_SHIFT) : (wide << SEG_SHIFT);
    endfunction

    assign seg_base_w = {min_blk_w, {SEG_SHIFT{1'b0}}};

    assign req_ready  = (r_q.state == ST_IDLE);
    assign txn_valid  = (r_q.state == ST_ISSUE) && any_w;
    assign txn_addr   = (r_q.gran == GRAN_LINE)
                        ? (seg_base_w << (LINE_SHIFT - SEG_SHIFT)) : seg_base_w;
    assign done_valid = r_q.done;
    assign done_count = r_q.done_count;
    assign done_bytes = r_q.done_bytes;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.gran  = coal_gran_e'(req_mode);
                    r_d.pend  = req_active;
                    r_d.blk   = in_blk_w;
                    r_d.count = '0;
                    if (req_active == '0) begin
                        r_d.done       = 1'b1;
                        r_d.done_count = '0;
                        r_d.done_bytes = '0;
                    end else begin
                        r_d.state = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (txn_valid && txn_ready) begin
                    r_d.pend  = pend_left_w;
                    r_d.count = r_q.count + 1'b1;
                    if (pend_left_w == '0) begin
                        r_d.state      = ST_IDLE;
                        r_d.done       = 1'b1;
                        r_d.done_count = r_q.count + 1'b1;
                        r_d.done_bytes = bytes_of(r_q.count + 1'b1, r_q.gran);
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int SEG_SHIFT  = 5,
    parameter int LINE_SHIFT = 7,
    parameter int CNT_W      = 6,
    parameter int BYTES_W    = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               req_mode,
    input logic [LANES-1:0]   req_active,
    input logic               txn_valid,
    input logic               txn_ready,
    input logic [ADDR_W-1:0]  txn_addr,
    input logic               done_valid,
    input logic [CNT_W-1:0]   done_count,
    input logic [BYTES_W-1:0] done_bytes
);

    logic              mode_q;
    logic              seen_q;
    logic [ADDR_W-1:0] last_q;
    logic [CNT_W-1:0]  hs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            seen_q <= 1'b0;
            last_q <= '0;
            hs_q   <= '0;
        end else begin
            if (req_valid && req_ready) begin
                mode_q <= req_mode;
                seen_q <= 1'b0;
                hs_q   <= '0;
            end else if (txn_valid && txn_ready) begin
                seen_q <= 1'b1;
                last_q <= txn_addr;
                hs_q   <= hs_q + 1'b1;
            end
        end
    end

    assert_line_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && mode_q |-> txn_addr[LINE_SHIFT-1:0] == '0);

    assert_seg_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !mode_q |-> txn_addr[SEG_SHIFT-1:0] == '0);

    assert_empty_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_active == '0 |=> done_valid && done_count == '0);

    assert_rising_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_ready && seen_q |-> txn_addr > last_q);

    assert_hold_offer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr));

    assert_busy_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> !req_ready);

    assert_done_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> done_count == hs_q);

    assert_done_bytes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> done_bytes == (mode_q ? (BYTES_W'(done_count) << LINE_SHIFT)
                                             : (BYTES_W'(done_count) << SEG_SHIFT)));

endmodule

bind warp_coalescer warp_coalescer_chk #(
    .LANES(LANES), .ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT),
    .LINE_SHIFT(LINE_SHIFT), .CNT_W(CNT_W), .BYTES_W(BYTES_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_active(req_active), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_addr(txn_addr), .done_valid(done_valid),
    .done_count(done_count), .done_bytes(done_bytes)
);

// File: tb/warp_coalescer_tb_top.sv
`timescale 1ns/1ps
module warp_coalescer_tb_top;

    localparam int LANES  = 32;
    localparam int ADDR_W = 32;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic                    req_mode = 1'b0;
    logic [LANES-1:0]        req_active = '0;
    logic [LANES*ADDR_W-1:0] req_addr = '0;
    logic                    txn_valid;
    logic                    txn_ready = 1'b0;
    logic [ADDR_W-1:0]       txn_addr;
    logic                    done_valid;
    logic [5:0]              done_count;
    logic [12:0]             done_bytes;

    always #2.5 clk = ~clk;

    warp_coalescer dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_active(req_active), .req_addr(req_addr),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr),
        .done_valid(done_valid), .done_count(done_count), .done_bytes(done_bytes)
    );

    typedef struct packed {
        logic        mode;
        logic        perm;
        logic [31:0] mask;
        logic [31:0] base;
        logic [15:0] stride;
        logic [5:0]  expn;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_1000, 16'd4,   6'd1 },
        '{1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_1000, 16'd4,   6'd4 },
        '{1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_2000, 16'd4,   6'd1 },
        '{1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_2000, 16'd4,   6'd4 },
        '{1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_1004, 16'd4,   6'd2 },
        '{1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_1004, 16'd4,   6'd5 },
        '{1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_1020, 16'd4,   6'd4 },
        '{1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_3008, 16'd0,   6'd1 },
        '{1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_3008, 16'd0,   6'd1 },
        '{1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 16'd256, 6'd32},
        '{1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 16'd64,  6'd16},
        '{1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 16'd64,  6'd32},
        '{1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0100, 16'd8,   6'd8 },
        '{1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_0100, 16'd8,   6'd2 },
        '{1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_0000, 16'd4,   6'd2 },
        '{1'b0, 1'b0, 32'h8000_0001, 32'h0000_0000, 16'd4,   6'd2 },
        '{1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000, 16'd4,   6'd0 },
        '{1'b0, 1'b0, 32'h0000_0000, 32'h0000_5004, 16'd128, 6'd0 },
        '{1'b0, 1'b0, 32'hAAAA_AAAA, 32'hFFFF_FF00, 16'd4,   6'd4 }
    };

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] lane_addr [LANES];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic string tag_of(input int i);
        if (i < 4)  return "R3";
        if (i < 7)  return "R4";
        if (i < 9)  return "R5";
        if (i < 14) return "R6";
        if (i < 16) return "R7";
        if (i < 18) return "R8";
        return "R2";
    endfunction

    function automatic bit in_req(input logic [31:0] a, input logic mode,
                                  input logic [31:0] mask);
        logic [31:0] m;
        m = mode ? 32'hFFFF_FF80 : 32'hFFFF_FFE0;
        for (int i = 0; i < LANES; i++)
            if (mask[i] && ((lane_addr[i] & m) == a)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int model_count(input logic mode, input logic [31:0] mask);
        logic [31:0] m;
        int n;
        bit dup;
        m = mode ? 32'hFFFF_FF80 : 32'hFFFF_FFE0;
        n = 0;
        for (int i = 0; i < LANES; i++) begin
            if (mask[i]) begin
                dup = 1'b0;
                for (int j = 0; j < i; j++)
                    if (mask[j] && ((lane_addr[j] & m) == (lane_addr[i] & m))) dup = 1'b1;
                if (!dup) n++;
            end
        end
        return n;
    endfunction

    task automatic fill_lanes(input vec_t v);
        for (int i = 0; i < LANES; i++) begin
            int idx;
            idx = v.perm ? ((i * 7 + 3) % LANES) : i;
            lane_addr[i] = v.base + 32'(v.stride) * 32'(idx);
        end
    endtask

    task automatic drive_req(input logic mode, input logic [31:0] mask);
        req_valid  = 1'b1;
        req_mode   = mode;
        req_active = mask;
        for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = lane_addr[i];
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    // Called at a negedge; returns at the negedge where done_valid is seen.
    task automatic run_req(input logic mode, input logic [31:0] mask,
                           input int expn, input bit bp, input string tag);
        int k, got, last_hs, size;
        bit finished, held;
        logic [31:0] last, held_addr;
        size = mode ? 128 : 32;
        check(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);
        check(model_count(mode, mask) == expn, tag, "model block count",
              model_count(mode, mask), expn);
        drive_req(mode, mask);
        k = 0; got = 0; last_hs = -1; finished = 1'b0; held = 1'b0; last = '0; held_addr = '0;
        while (!finished && k < 400) begin
            @(negedge clk);
            if (done_valid) begin
                finished = 1'b1;
                txn_ready = 1'b0;
                check(done_count == 6'(expn), tag, "done_count", done_count, expn);
                check(done_bytes == 13'(expn * size), tag, "done_bytes", done_bytes, expn * size);
                check(k == last_hs + 1, "R11", "done cycle", k, last_hs + 1);
                check(got == expn, "R11", "handshake count", got, expn);
                check(req_ready == 1'b1, "R10", "ready with done", req_ready, 1);
            end else if (txn_valid) begin
                check(req_ready == 1'b0, "R10", "busy while issuing", req_ready, 0);
                if (held) check(txn_addr == held_addr, "R10", "addr held", txn_addr, held_addr);
                txn_ready = bp ? ((k % 3) == 2) : 1'b1;
                if (txn_ready) begin
                    if (got > 0) check(txn_addr > last, "R9", "ascending", txn_addr, last);
                    check(in_req(txn_addr, mode, mask), mode ? "R1" : "R2",
                          "block touched by active lane", txn_addr, 0);
                    check(mode ? (txn_addr[6:0] == 0) : (txn_addr[4:0] == 0),
                          mode ? "R1" : "R2", "alignment", txn_addr, 0);
                    last = txn_addr; got++; last_hs = k; held = 1'b0;
                end else begin
                    held = 1'b1; held_addr = txn_addr;
                end
            end else begin
                txn_ready = 1'b0;
            end
            k++;
        end
        if (!finished) check(1'b0, "R11", "no done pulse", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R11", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R12", "req_ready in reset", req_ready, 1);
        check(txn_valid == 1'b0, "R12", "txn_valid in reset", txn_valid, 0);
        check(done_valid == 1'b0, "R12", "done_valid in reset", done_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk; each request is driven in the cycle its predecessor completes.
        for (int v = 0; v < NVEC; v++) begin
            fill_lanes(VECS[v]);
            run_req(VECS[v].mode, VECS[v].mask, int'(VECS[v].expn), (v % 2) == 1, tag_of(v));
        end

        // R7: inactive lanes point at far-away blocks and must not appear.
        for (int i = 0; i < LANES; i++) lane_addr[i] = (i < 4) ? 32'h40 + 32'(i*4) : 32'h9000_0000 + 32'(i*512);
        run_req(1'b0, 32'h0000_000F, 1, 1'b0, "R7");

        // Back-to-back empty requests: R8 completion overlaps next acceptance.
        run_req(1'b1, 32'h0, 0, 1'b0, "R8");
        run_req(1'b0, 32'h0, 0, 1'b0, "R8");

        // R12: reset in the middle of a stalled request.
        fill_lanes(VECS[9]);
        drive_req(1'b1, 32'hFFFF_FFFF);
        txn_ready = 1'b0;
        repeat (3) @(negedge clk);
        check(txn_valid == 1'b1, "R10", "offer stays while stalled", txn_valid, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(txn_valid == 1'b0, "R12", "txn_valid after mid reset", txn_valid, 0);
        check(req_ready == 1'b1, "R12", "req_ready after mid reset", req_ready, 1);
        check(done_valid == 1'b0, "R12", "done_valid after mid reset", done_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        fill_lanes(VECS[5]);
        run_req(1'b0, 32'hFFFF_FFFF, 5, 1'b1, "R4");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule